// File: doc/BRIEF.md
# Protected Fully Associative Address Translation Cache

This block holds a handful of recent page mappings and turns a 32-bit virtual address into a physical address within the same cycle. Pages are 4 KB. The low 12 address bits pass straight through. The upper 20 bits are compared at the same time against every stored entry. Each entry also records whether the page may be read and whether it may be written. A lookup that matches an entry but asks for a disallowed access reports a protection fault instead of an address.

When a lookup misses, an external walker or a software handler finds the mapping and writes it through the fill port. The slot it lands in is chosen in this order:
- an entry that already holds the same virtual page number;
- otherwise the lowest-numbered empty entry;
- otherwise the entry named by a free-running 4-bit linear feedback shift register.

A single flush input drops every mapping at once.

Top module: `ptlb_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, every entry is empty, so every lookup reports a miss. Reset loads the shift register with the value 1.
- R2: A lookup whose page number (`lk_vaddr[31:12]`) equals that of a valid entry sets `lk_hit` in the same cycle, with no clock edge in between. If the access is allowed, `lk_paddr[31:12]` is that entry's frame number.
- R3: On every allowed hit, `lk_paddr[11:0]` equals `lk_vaddr[11:0]`.
- R4: The required permission depends on `lk_write`: a write (`lk_write`=1) needs the entry's write permission and a read (`lk_write`=0) needs its read permission. A hit without the required permission sets `lk_fault`=1, `lk_pa_valid`=0 and `lk_paddr`=0. A permitted hit sets `lk_pa_valid`=1 and `lk_fault`=0.
- R5: A miss sets `lk_hit`=0, `lk_fault`=0, `lk_pa_valid`=0 and `lk_paddr`=0.
- R6: A fill whose page number is already held by a valid entry overwrites that entry on the next clock edge, so no page number is ever held twice.
- R7: Otherwise a fill goes to the lowest-indexed invalid entry, written on the next clock edge.
- R8: When all entries are valid, a fill with a new page number replaces the entry whose index equals the current shift-register state. The register moves on every clock edge out of reset, by the rule next = {s[2:0], s[3]^s[2]}.
- R9: `inv_all` clears every valid bit on the next clock edge. It takes precedence over a fill requested in the same cycle, and that fill is dropped.
- R10: No lookup page number ever matches more than one valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Flush every mapping |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup access kind: 1 write, 0 read |
| fill_en | input | 1 | Write a mapping on this clock edge |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |
| fill_rd_ok | input | 1 | Read permission of the new mapping |
| fill_wr_ok | input | 1 | Write permission of the new mapping |
| lk_hit | output | 1 | Page number found in a valid entry |
| lk_fault | output | 1 | Hit, but the access kind is not permitted |
| lk_pa_valid | output | 1 | `lk_paddr` holds a usable translation |
| lk_paddr | output | 32 | Physical address, zero unless usable |

## Verification
The following hold in every cycle and are watched continuously:
- at most one entry matches a lookup;
- a fault never comes with a usable address;
- reset and flush leave no valid entries;
- a refill of a page number that is already present never adds an entry;
- the shift register never reaches zero;
- a random victim is taken only when every entry is full.

Two behaviours can only be shown by stimulus, because they depend on a sequence of fills followed by lookups of every page number held:
- which entry a full array actually evicts;
- that the frame number and offset come out correctly.

The bench therefore keeps a reference model of the entries and of the shift register.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
    parameter int unsigned VA_W  = 32;
    parameter int unsigned OFF_W = 12;
    parameter int unsigned PFN_W = 20;
    localparam int unsigned VPN_W = VA_W - OFF_W;
    localparam int unsigned PA_W  = PFN_W + OFF_W;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;
    typedef logic [OFF_W-1:0] off_t;

    typedef struct packed {
        logic valid;
        logic rd_ok;
        logic wr_ok;
        vpn_t vpn;
        pfn_t pfn;
    } slot_t;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
        vpn_t vpn;
        pfn_t pfn;
    } fill_req_t;

    typedef struct packed {
        logic hit;
        logic rd_ok;
        logic wr_ok;
        pfn_t pfn;
    } lookup_res_t;

    typedef enum logic [1:0] {
        SRC_SAME   = 2'd0,
        SRC_FREE   = 2'd1,
        SRC_RANDOM = 2'd2
    } victim_src_e;

    // Maximal-length feedback masks for small shift registers.
    function automatic logic [7:0] lfsr_mask(input int unsigned w);
        case (w)
            2:       return 8'h03;
            3:       return 8'h06;
            4:       return 8'h0C;
            5:       return 8'h14;
            6:       return 8'h30;
            7:       return 8'h60;
            default: return 8'hB8;
        endcase
    endfunction
endpackage

// File: rtl/ptlb_victim_lfsr.sv
module ptlb_victim_lfsr
    import ptlb_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] state
);
    localparam logic [7:0]   MASK8 = lfsr_mask(W);
    localparam logic [W-1:0] TAPS  = MASK8[W-1:0];

    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= W'(1);
        else     state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
    end

    assign state = state_q;

    // R8
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);
endmodule

// File: rtl/ptlb_victim_sel.sv
module ptlb_victim_sel
    import ptlb_pkg::*;
#(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  fl_match,
    input  logic [N-1:0]  valid_vec,
    input  logic [IW-1:0] rnd,
    output logic [IW-1:0] idx,
    output victim_src_e   src
);
    always_comb begin
        idx = rnd;
        src = SRC_RANDOM;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                idx = IW'(i);
                src = SRC_FREE;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (fl_match[i]) begin
                idx = IW'(i);
                src = SRC_SAME;
            end
        end
    end

    // R8
    always_comb begin
        random_only_when_full_chk: assert (src != SRC_RANDOM || (&valid_vec));
    end
endmodule

// File: rtl/ptlb_entry_array.sv
module ptlb_entry_array
    import ptlb_pkg::*;
#(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inv_all,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  fill_req_t     wr_data,
    input  vpn_t          lk_vpn,
    input  vpn_t          fl_vpn,
    output logic [N-1:0]  lk_match,
    output logic [N-1:0]  fl_match,
    output logic [N-1:0]  valid_vec,
    output lookup_res_t   lk_res
);
    pfn_t       pfn_arr [N];
    logic [N-1:0] rd_arr;
    logic [N-1:0] wr_arr;

    for (genvar g = 0; g < N; g++) begin : g_slot
        slot_t slot_q;

        always_ff @(posedge clk) begin
            if (rst || inv_all) begin
                slot_q.valid <= 1'b0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                slot_q <= '{valid: 1'b1, rd_ok: wr_data.rd_ok, wr_ok: wr_data.wr_ok,
                            vpn: wr_data.vpn, pfn: wr_data.pfn};
            end
        end

        assign lk_match[g]  = slot_q.valid && (slot_q.vpn == lk_vpn);
        assign fl_match[g]  = slot_q.valid && (slot_q.vpn == fl_vpn);
        assign valid_vec[g] = slot_q.valid;
        assign pfn_arr[g]   = slot_q.pfn;
        assign rd_arr[g]    = slot_q.rd_ok;
        assign wr_arr[g]    = slot_q.wr_ok;
    end

    // One-hot select: OR together the fields of the matching slot.
    always_comb begin
        lk_res = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) begin
                lk_res.hit   = 1'b1;
                lk_res.rd_ok = lk_res.rd_ok | rd_arr[i];
                lk_res.wr_ok = lk_res.wr_ok | wr_arr[i];
                lk_res.pfn   = lk_res.pfn | pfn_arr[i];
            end
        end
    end

    // R10
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (valid_vec == '0));

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0));
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
    import ptlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inv_all,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_write,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_rd_ok,
    input  logic              fill_wr_ok,
    output logic              lk_hit,
    output logic              lk_fault,
    output logic              lk_pa_valid,
    output logic [PA_W-1:0]   lk_paddr
);
    localparam int unsigned IW = $clog2(ENTRIES);

    logic [ENTRIES-1:0] lk_match, fl_match, valid_vec;
    logic [IW-1:0]      rnd_idx, wr_idx;
    victim_src_e        src;
    lookup_res_t        res;
    fill_req_t          req;
    logic               wr_en, allowed;
    vpn_t               lk_vpn;
    off_t               lk_off;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];
    assign req    = '{rd_ok: fill_rd_ok, wr_ok: fill_wr_ok, vpn: fill_vpn, pfn: fill_pfn};
    assign wr_en  = fill_en && !inv_all;

    ptlb_victim_lfsr #(.W(IW)) lfsr_i (
        .clk   (clk),
        .rst   (rst),
        .state (rnd_idx)
    );

    ptlb_victim_sel #(.N(ENTRIES), .IW(IW)) sel_i (
        .fl_match  (fl_match),
        .valid_vec (valid_vec),
        .rnd       (rnd_idx),
        .idx       (wr_idx),
        .src       (src)
    );

    ptlb_entry_array #(.N(ENTRIES), .IW(IW)) arr_i (
        .clk       (clk),
        .rst       (rst),
        .inv_all   (inv_all),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (req),
        .lk_vpn    (lk_vpn),
        .fl_vpn    (fill_vpn),
        .lk_match  (lk_match),
        .fl_match  (fl_match),
        .valid_vec (valid_vec),
        .lk_res    (res)
    );

    always_comb begin
        allowed     = lk_write ? res.wr_ok : res.rd_ok;
        lk_hit      = res.hit;
        lk_fault    = res.hit && !allowed;
        lk_pa_valid = res.hit && allowed;
        lk_paddr    = lk_pa_valid ? {res.pfn, lk_off} : '0;
    end

    // R4
    fault_blocks_addr_chk: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> (!lk_pa_valid && lk_paddr == '0));

    // R5
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (!lk_fault && !lk_pa_valid));

    // R6
    refill_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (|fl_match)) |=> ($countones(valid_vec) == $past($countones(valid_vec))));
endmodule

// File: tb/ptlb_top_tb_top.sv
module ptlb_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inv_all = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_rd_ok = 1'b0;
    logic        fill_wr_ok = 1'b0;
    logic        lk_hit, lk_fault, lk_pa_valid;
    logic [31:0] lk_paddr;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ptlb_top dut_i (
        .clk(clk), .rst(rst), .inv_all(inv_all), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_rd_ok(fill_rd_ok), .fill_wr_ok(fill_wr_ok),
        .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_pa_valid(lk_pa_valid), .lk_paddr(lk_paddr)
    );

    // Reference model
    bit          mv  [16];
    logic [19:0] mvpn[16];
    logic [19:0] mpfn[16];
    bit          mr  [16];
    bit          mw  [16];
    logic [3:0]  ml;

    function automatic int model_victim(input logic [19:0] vpn);
        for (int i = 0; i < 16; i++) if (mv[i] && mvpn[i] == vpn) return i;
        for (int i = 0; i < 16; i++) if (!mv[i]) return i;
        return int'(ml);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) mv[i] = 1'b0;
            ml = 4'd1;
        end else begin
            if (inv_all) begin
                for (int i = 0; i < 16; i++) mv[i] = 1'b0;
            end else if (fill_en) begin
                int v;
                v = model_victim(fill_vpn);
                mv[v] = 1'b1; mvpn[v] = fill_vpn; mpfn[v] = fill_pfn;
                mr[v] = fill_rd_ok; mw[v] = fill_wr_ok;
            end
            ml = {ml[2:0], ml[3] ^ ml[2]};
        end
    end

    function automatic logic [34:0] expect_of(input logic [19:0] vpn, input logic [11:0] off,
                                              input bit wr);
        for (int i = 0; i < 16; i++) begin
            if (mv[i] && mvpn[i] == vpn) begin
                if (wr ? mw[i] : mr[i]) return {1'b1, 1'b0, 1'b1, mpfn[i], off};
                return {1'b1, 1'b1, 1'b0, 32'd0};
            end
        end
        return 35'd0;
    endfunction

    // Drive a lookup just after a falling edge and compare against the model.
    task automatic chk(input logic [19:0] vpn, input logic [11:0] off, input bit wr,
                       input string tag);
        logic [34:0] exp, act;
        string t;
        lk_vaddr = {vpn, off};
        lk_write = wr;
        #1;
        exp = expect_of(vpn, off, wr);
        act = {lk_hit, lk_fault, lk_pa_valid, lk_paddr};
        t = tag;
        if (t == "") t = !exp[34] ? "R5" : (exp[33] ? "R4" : "R2/R3");
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s vpn=%h wr=%0d act{hit,fault,ok,pa}=%h exp=%h", t, vpn, wr, act, exp);
        end
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn, input bit r,
                           input bit w);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_rd_ok = r; fill_wr_ok = w;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic check_count(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s resident count act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        chk(20'h00000, 12'h000, 1'b0, "R1");
        @(negedge clk);
        rst = 1'b0;
        chk(20'h00000, 12'h123, 1'b0, "R1");
        chk(20'h12345, 12'h456, 1'b1, "R1");

        // Read-only page: read translates, write faults
        do_fill(20'h12345, 20'hABCDE, 1'b1, 1'b0);
        chk(20'h12345, 12'h000, 1'b0, "R2");
        chk(20'h12345, 12'hFFF, 1'b0, "R3");
        chk(20'h12345, 12'h5A5, 1'b1, "R4");
        // Refill same page: overwritten in place, now writable, no-read
        do_fill(20'h12345, 20'h11111, 1'b0, 1'b1);
        chk(20'h12345, 12'h010, 1'b1, "R6");
        chk(20'h12345, 12'h010, 1'b0, "R4");
        // 14 more distinct pages, then one more: all must still be resident
        for (int i = 0; i < 14; i++) do_fill(20'h00100 + 20'(i), 20'h40000 + 20'(i), 1'b1, 1'b1);
        do_fill(20'h00200, 20'h50000, 1'b1, 1'b1);
        n = 0;
        for (int i = 0; i < 14; i++) begin
            chk(20'h00100 + 20'(i), 12'h321, 1'b0, "R7");
            n += int'(lk_hit);
        end
        chk(20'h12345, 12'h001, 1'b1, "R7"); n += int'(lk_hit);
        chk(20'h00200, 12'h002, 1'b0, "R7"); n += int'(lk_hit);
        check_count(n, 16, "R6/R7");
        // Full array: new page evicts the shift-register victim
        do_fill(20'h00300, 20'h60000, 1'b1, 1'b0);
        n = 0;
        for (int i = 0; i < 14; i++) begin
            chk(20'h00100 + 20'(i), 12'h0AB, 1'b0, "R8");
            n += int'(lk_hit);
        end
        chk(20'h12345, 12'h0AB, 1'b1, "R8"); n += int'(lk_hit);
        chk(20'h00200, 12'h0AB, 1'b0, "R8"); n += int'(lk_hit);
        chk(20'h00300, 12'h0AB, 1'b0, "R8"); n += int'(lk_hit);
        check_count(n, 16, "R8");
        // Flush together with a fill: flush wins
        @(negedge clk);
        inv_all = 1'b1; fill_en = 1'b1; fill_vpn = 20'h00777; fill_pfn = 20'h77777;
        fill_rd_ok = 1'b1; fill_wr_ok = 1'b1;
        @(negedge clk);
        inv_all = 1'b0; fill_en = 1'b0;
        chk(20'h00777, 12'h000, 1'b0, "R9");
        chk(20'h00300, 12'h000, 1'b0, "R9");
        chk(20'h12345, 12'h000, 1'b1, "R9");

        // Constrained random traffic over a small page pool
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            fill_en    = ($urandom_range(0, 99) < 40);
            inv_all    = ($urandom_range(0, 199) == 0);
            fill_vpn   = 20'h80000 + 20'($urandom_range(0, 23));
            fill_pfn   = 20'($urandom);
            fill_rd_ok = 1'($urandom);
            fill_wr_ok = 1'($urandom);
            chk(20'h80000 + 20'($urandom_range(0, 23)), 12'($urandom), 1'($urandom), "");
        end
        @(negedge clk);
        fill_en = 1'b0; inv_all = 1'b0;
        chk(20'h80005, 12'h00F, 1'b0, "");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule